// File: doc/BRIEF.md
# Host Command Decoder and Interrupt Status Unit

This unit sits behind the host register port of a network adapter. The host writes a 16-bit command word into one write-only port. The unit splits that word into a 5-bit opcode and an 11-bit argument and acts on the opcode. The commands select a register window, switch the receiver and transmitter on or off, store three threshold values, request or acknowledge interrupts, load the interrupt mask, and start a global reset.

The unit also keeps a 16-bit status word that the host can read back at any time. The word holds sticky event bits, which single-cycle pulses from the rest of the adapter set and which stay set until the host acknowledges them. It also holds the number of the selected window and a command-busy flag. An interrupt latch bit, and with it the interrupt output, is high while any sticky bit that the mask enables is set.

A two-state controller governs command acceptance:
- ST_RUN: commands are accepted.
- ST_GRST: a global reset is in progress. The busy flag is high and both commands and events are ignored.

The controller has three transitions:
- ST_RUN to ST_GRST on an accepted global-reset command.
- ST_GRST to itself while the wait counter is non-zero.
- ST_GRST to ST_RUN when the counter reaches zero.

The wait lasts `RST_CYC` cycles. It models the required host wait of at least 1 ms, which is 200,000 cycles at 200 MHz.

Top module: `nic_cmd_ctrl`

## Requirements
- R1: A command word carries the opcode in bits 15..11 and the argument in bits 10..0. For opcodes that take no argument, the argument value has no effect.
- R2: Opcode 0x01 selects window `arg[2:0]`. Status bits 15..13 report the selected window, which is 0 after power-up.
- R3: The status word is laid out as follows: bit 0 interrupt latch, bit 1 adapter failure, bit 2 transmit complete, bit 3 transmit available, bit 4 receive complete, bit 5 receive early, bit 6 interrupt requested, bit 7 update statistics, bit 12 command in progress. Bits 11..8 read as 0.
- R4: Opcode 0x0C sets status bit 6.
- R5: Opcode 0x0D clears every sticky status bit (bits 7..1) whose position is set in the argument.
- R6: Opcode 0x0E loads the interrupt mask from `arg[7:1]`. Status bit 0 and `irq_o` are high exactly while some sticky bit and its mask bit are both set. The mask is 0 after power-up.
- R7: Opcode 0x00 performs a global reset. Status bit 12 is high for exactly `RST_CYC` cycles. The window, the sticky bits, the mask, the enables and the thresholds return to their power-up values. Commands and events that arrive while bit 12 is high are ignored.
- R8: Opcodes 0x03 and 0x04 turn the receiver off and on. Opcodes 0x09 and 0x0A turn the transmitter on and off. Both are off after power-up.
- R9: Opcodes 0x11, 0x12 and 0x13 store the argument as the receive-early, transmit-available and transmit-start thresholds. `thr_off_o` bits 0, 1 and 2 are high while the matching threshold equals 2047, which is also the power-up value.
- R10: Event input bits 1, 2, 3, 4, 5 and 7 set the status bits at the same positions. Event bits 0 and 6 have no effect. A set and an acknowledge of the same bit in the same cycle leave the bit set.
- R11: Any other opcode (0x02, 0x05 to 0x08, 0x0B, 0x0F, 0x10, and 0x14 to 0x1F) changes no state.
- R12: Every command and event takes effect on the clock edge that samples it and is visible in the cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Command write strobe |
| cmd_data | input | 16 | Command word: opcode and argument |
| event_i | input | 8 | Single-cycle event pulses by status bit position |
| status_o | output | 16 | Status word |
| irq_o | output | 1 | Interrupt request |
| rx_en_o | output | 1 | Receiver enable |
| tx_en_o | output | 1 | Transmitter enable |
| thr_rxe_o | output | 11 | Receive-early threshold |
| thr_txa_o | output | 11 | Transmit-available threshold |
| thr_txs_o | output | 11 | Transmit-start threshold |
| thr_off_o | output | 3 | Threshold disabled flags (bit 0 receive-early, bit 1 transmit-available, bit 2 transmit-start) |

## Verification
Every command and event result is due exactly one cycle after the edge that samples it, and the busy flag then stays high for `RST_CYC` further samples. The driver stamps each expected result with the cycle number in which it is due. The monitor compares it in that cycle, at the falling edge, and never earlier. While the busy flag is high, the stimulus keeps sending commands and events so that the ignore rule is seen at the ports.

// File: rtl/nic_cmd_pkg.sv
package nic_cmd_pkg;
    localparam int CMD_W = 16;
    localparam int OP_W  = 5;
    localparam int ARG_W = CMD_W - OP_W;
    localparam int WIN_W = 3;
    localparam int EVT_W = 8;
    localparam int THR_N = 3;
    localparam int PAD_W = CMD_W - WIN_W - 1 - EVT_W;

    localparam logic [ARG_W-1:0] THR_OFF = '1;

    // status bit positions
    localparam int BIT_LATCH  = 0;
    localparam int BIT_IRQREQ = 6;

    // bits that can hold a sticky value; bit 0 is derived
    localparam logic [EVT_W-1:0] STICKY_BITS = 8'hFE;
    // bits an event pulse may set; bit 6 is command-only
    localparam logic [EVT_W-1:0] EVENT_SRC   = 8'hBE;

    typedef enum logic [OP_W-1:0] {
        OP_GRESET  = 5'h00,
        OP_WINSEL  = 5'h01,
        OP_RXOFF   = 5'h03,
        OP_RXON    = 5'h04,
        OP_TXON    = 5'h09,
        OP_TXOFF   = 5'h0A,
        OP_IRQREQ  = 5'h0C,
        OP_ACK     = 5'h0D,
        OP_MASK    = 5'h0E,
        OP_THR_RXE = 5'h11,
        OP_THR_TXA = 5'h12,
        OP_THR_TXS = 5'h13
    } opcode_e;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_GRST = 1'b1
    } ctl_state_e;

    typedef struct packed {
        logic             grst;
        logic             winsel;
        logic             rx_off;
        logic             rx_on;
        logic             tx_on;
        logic             tx_off;
        logic             irqreq;
        logic             ack;
        logic             mask;
        logic [THR_N-1:0] thr;
    } cmd_strobe_t;
endpackage

// File: rtl/nic_cmd_decode.sv
module nic_cmd_decode
    import nic_cmd_pkg::*;
(
    input  logic             valid_i,
    input  logic [CMD_W-1:0] cmd_i,
    output cmd_strobe_t      strb_o,
    output logic [ARG_W-1:0] arg_o
);
    logic [OP_W-1:0] op;

    assign op    = cmd_i[CMD_W-1:ARG_W];
    assign arg_o = cmd_i[ARG_W-1:0];

    always_comb begin
        strb_o = '0;
        if (valid_i) begin
            unique case (op)
                OP_GRESET:  strb_o.grst   = 1'b1;
                OP_WINSEL:  strb_o.winsel = 1'b1;
                OP_RXOFF:   strb_o.rx_off = 1'b1;
                OP_RXON:    strb_o.rx_on  = 1'b1;
                OP_TXON:    strb_o.tx_on  = 1'b1;
                OP_TXOFF:   strb_o.tx_off = 1'b1;
                OP_IRQREQ:  strb_o.irqreq = 1'b1;
                OP_ACK:     strb_o.ack    = 1'b1;
                OP_MASK:    strb_o.mask   = 1'b1;
                OP_THR_RXE: strb_o.thr[0] = 1'b1;
                OP_THR_TXA: strb_o.thr[1] = 1'b1;
                OP_THR_TXS: strb_o.thr[2] = 1'b1;
                default:    strb_o = '0;
            endcase
        end
    end
endmodule

// File: rtl/nic_cmd_fsm.sv
module nic_cmd_fsm
    import nic_cmd_pkg::*;
#(
    parameter int RST_CYC = 200000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_we,
    input  logic grst_i,
    output logic accept_o,
    output logic busy_o
);
    localparam int CNT_W = (RST_CYC > 1) ? $clog2(RST_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RST_CYC - 1);

    ctl_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_RUN: begin
                if (grst_i) begin
                    state_d = ST_GRST;
                    cnt_d   = CNT_LOAD;
                end
            end
            ST_GRST: begin
                if (cnt_q == '0) begin
                    state_d = ST_RUN;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: state_d = ST_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        busy_o   = (state_q == ST_GRST);
        accept_o = cmd_we && (state_q == ST_RUN);
    end
endmodule

// File: rtl/nic_evt_status.sv
module nic_evt_status
    import nic_cmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             hold_i,
    input  logic [EVT_W-1:0] event_i,
    input  logic             irqreq_i,
    input  logic             ack_i,
    input  logic             mask_ld_i,
    input  logic [EVT_W-1:0] arg_i,
    output logic [EVT_W-1:0] bits_o,
    output logic             irq_o
);
    logic [EVT_W-1:0] sticky_q, mask_q;
    logic [EVT_W-1:0] set_v, clr_v;
    logic             latch;

    always_comb begin
        set_v = hold_i ? '0 : (event_i & EVENT_SRC);
        if (irqreq_i) begin
            set_v[BIT_IRQREQ] = 1'b1;
        end
        clr_v = ack_i ? (arg_i & STICKY_BITS) : '0;
    end

    // a set in the same cycle as an acknowledge wins
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sticky_q <= '0;
        end else if (clear_i) begin
            sticky_q <= '0;
        end else begin
            sticky_q <= (set_v | (sticky_q & ~clr_v)) & STICKY_BITS;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (clear_i) begin
            mask_q <= '0;
        end else if (mask_ld_i) begin
            mask_q <= arg_i & STICKY_BITS;
        end
    end

    assign latch = |(sticky_q & mask_q);

    always_comb begin
        bits_o            = sticky_q;
        bits_o[BIT_LATCH] = latch;
        irq_o             = latch;
    end
endmodule

// File: rtl/nic_cmd_regs.sv
module nic_cmd_regs
    import nic_cmd_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clear_i,
    input  cmd_strobe_t            strb_i,
    input  logic [ARG_W-1:0]       arg_i,
    output logic [WIN_W-1:0]       win_o,
    output logic                   rx_en_o,
    output logic                   tx_en_o,
    output logic [THR_N*ARG_W-1:0] thr_o,
    output logic [THR_N-1:0]       thr_off_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_o   <= '0;
            rx_en_o <= 1'b0;
            tx_en_o <= 1'b0;
        end else if (clear_i) begin
            win_o   <= '0;
            rx_en_o <= 1'b0;
            tx_en_o <= 1'b0;
        end else begin
            if (strb_i.winsel) win_o   <= arg_i[WIN_W-1:0];
            if (strb_i.rx_on)  rx_en_o <= 1'b1;
            if (strb_i.rx_off) rx_en_o <= 1'b0;
            if (strb_i.tx_on)  tx_en_o <= 1'b1;
            if (strb_i.tx_off) tx_en_o <= 1'b0;
        end
    end

    for (genvar i = 0; i < THR_N; i++) begin : g_thr
        logic [ARG_W-1:0] val_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                val_q <= THR_OFF;
            end else if (clear_i) begin
                val_q <= THR_OFF;
            end else if (strb_i.thr[i]) begin
                val_q <= arg_i;
            end
        end

        assign thr_o[i*ARG_W +: ARG_W] = val_q;
        assign thr_off_o[i]            = (val_q == THR_OFF);
    end
endmodule

// File: rtl/nic_cmd_ctrl.sv
module nic_cmd_ctrl
    import nic_cmd_pkg::*;
#(
    parameter int RST_CYC = 200000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_we,
    input  logic [15:0] cmd_data,
    input  logic [7:0]  event_i,
    output logic [15:0] status_o,
    output logic        irq_o,
    output logic        rx_en_o,
    output logic        tx_en_o,
    output logic [10:0] thr_rxe_o,
    output logic [10:0] thr_txa_o,
    output logic [10:0] thr_txs_o,
    output logic [2:0]  thr_off_o
);
    logic                   accept;
    logic                   busy;
    cmd_strobe_t            strb;
    logic [ARG_W-1:0]       arg;
    logic [WIN_W-1:0]       win;
    logic [EVT_W-1:0]       evt_bits;
    logic [THR_N*ARG_W-1:0] thr_all;

    nic_cmd_fsm #(.RST_CYC(RST_CYC)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_we   (cmd_we),
        .grst_i   (strb.grst),
        .accept_o (accept),
        .busy_o   (busy)
    );

    nic_cmd_decode u_dec (
        .valid_i (accept),
        .cmd_i   (cmd_data),
        .strb_o  (strb),
        .arg_o   (arg)
    );

    nic_evt_status u_evt (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (strb.grst),
        .hold_i    (busy),
        .event_i   (event_i),
        .irqreq_i  (strb.irqreq),
        .ack_i     (strb.ack),
        .mask_ld_i (strb.mask),
        .arg_i     (arg[EVT_W-1:0]),
        .bits_o    (evt_bits),
        .irq_o     (irq_o)
    );

    nic_cmd_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (strb.grst),
        .strb_i    (strb),
        .arg_i     (arg),
        .win_o     (win),
        .rx_en_o   (rx_en_o),
        .tx_en_o   (tx_en_o),
        .thr_o     (thr_all),
        .thr_off_o (thr_off_o)
    );

    assign thr_rxe_o = thr_all[0*ARG_W +: ARG_W];
    assign thr_txa_o = thr_all[1*ARG_W +: ARG_W];
    assign thr_txs_o = thr_all[2*ARG_W +: ARG_W];

    assign status_o = {win, busy, {PAD_W{1'b0}}, evt_bits};
endmodule

// File: rtl/nic_cmd_chk.sv
module nic_cmd_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_we,
    input logic [15:0] cmd_data,
    input logic [7:0]  event_i,
    input logic [15:0] status_o,
    input logic        irq_o,
    input logic        rx_en_o,
    input logic        tx_en_o,
    input logic [10:0] thr_rxe_o
);
    logic take;
    logic [4:0] op;
    assign take = cmd_we && !status_o[12];
    assign op   = cmd_data[15:11];

    a_r2_window_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (take && op == 5'h01) |=> status_o[15:13] == $past(cmd_data[2:0]));

    a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[11:8] == 4'h0);

    a_r6_mask_zero_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (take && op == 5'h0E && cmd_data[7:1] == 7'h0) |=> !irq_o && !status_o[0]);

    a_r7_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (take && op == 5'h00) |=> status_o[12] && status_o[7:0] == 8'h00 && !rx_en_o && !tx_en_o);

    a_r8_rx_on: assert property (@(posedge clk) disable iff (!rst_n)
        (take && op == 5'h04) |=> rx_en_o);

    a_r9_thr_store: assert property (@(posedge clk) disable iff (!rst_n)
        (take && op == 5'h11) |=> thr_rxe_o == $past(cmd_data[10:0]));

    a_r10_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (!status_o[12] && !(cmd_we && op == 5'h00))
        |=> ((status_o[7:0] & $past(event_i & 8'hBE)) == $past(event_i & 8'hBE)));

    a_r11_unknown_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (take && event_i == 8'h00 &&
         !(op inside {5'h00, 5'h01, 5'h03, 5'h04, 5'h09, 5'h0A, 5'h0C, 5'h0D,
                      5'h0E, 5'h11, 5'h12, 5'h13}))
        |=> $stable(status_o) && $stable(rx_en_o) && $stable(tx_en_o) && $stable(thr_rxe_o));
endmodule

bind nic_cmd_ctrl nic_cmd_chk u_chk (.*);

// File: tb/nic_cmd_ctrl_tb.sv
`timescale 1ns/1ps
module nic_cmd_ctrl_tb;
    localparam int RST = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_we = 1'b0;
    logic [15:0] cmd_data = 16'h0;
    logic [7:0]  event_i = 8'h0;
    logic [15:0] status_o;
    logic        irq_o, rx_en_o, tx_en_o;
    logic [10:0] thr_rxe_o, thr_txa_o, thr_txs_o;
    logic [2:0]  thr_off_o;

    nic_cmd_ctrl #(.RST_CYC(RST)) u_dut (.*);

    always #2.5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    typedef struct {
        int          due;
        string       req;
        logic [15:0] st;
        logic        irq, rx, tx;
        logic [2:0]  off;
        logic [10:0] t0, t1, t2;
    } exp_t;
    exp_t q[$];

    // reference state built from the requirements
    logic [2:0]  m_win = 3'd0;
    logic [7:0]  m_sticky = 8'h00;
    logic [7:0]  m_mask = 8'h00;
    logic        m_rx = 1'b0, m_tx = 1'b0;
    logic [10:0] m_t0 = 11'd2047, m_t1 = 11'd2047, m_t2 = 11'd2047;
    int          m_busy = 0;

    function automatic void compare(exp_t e);
        n_chk++;
        if (status_o !== e.st || irq_o !== e.irq || rx_en_o !== e.rx || tx_en_o !== e.tx ||
            thr_off_o !== e.off || thr_rxe_o !== e.t0 || thr_txa_o !== e.t1 || thr_txs_o !== e.t2) begin
            n_bad++;
            $display("FAIL %s: actual st=%h irq=%b rx=%b tx=%b off=%b thr=%0d/%0d/%0d expected st=%h irq=%b rx=%b tx=%b off=%b thr=%0d/%0d/%0d",
                     e.req, status_o, irq_o, rx_en_o, tx_en_o, thr_off_o, thr_rxe_o, thr_txa_o, thr_txs_o,
                     e.st, e.irq, e.rx, e.tx, e.off, e.t0, e.t1, e.t2);
        end
    endfunction

    function automatic exp_t snapshot(string req);
        exp_t e;
        logic latch;
        latch  = |(m_sticky & m_mask);
        e.due  = cyc + 1;
        e.req  = req;
        e.st   = {m_win, (m_busy > 0), 4'h0, m_sticky[7:1], latch};
        e.irq  = latch;
        e.rx   = m_rx;
        e.tx   = m_tx;
        e.off  = {m_t2 == 11'd2047, m_t1 == 11'd2047, m_t0 == 11'd2047};
        e.t0   = m_t0;
        e.t1   = m_t1;
        e.t2   = m_t2;
        return e;
    endfunction

    // driver: one cycle of stimulus, expected result queued for the next cycle
    task automatic step(input logic we, input logic [15:0] d, input logic [7:0] ev, input string req);
        logic [7:0] setv, clrv;
        @(posedge clk);
        #1;
        cmd_we   = we;
        cmd_data = d;
        event_i  = ev;
        setv = 8'h00;
        clrv = 8'h00;
        if (m_busy > 0) begin
            m_busy--;
        end else begin
            setv = ev & 8'hBE;
            if (we) begin
                case (d[15:11])
                    5'h00: begin
                        m_win = 3'd0; m_sticky = 8'h00; m_mask = 8'h00;
                        m_rx = 1'b0; m_tx = 1'b0;
                        m_t0 = 11'd2047; m_t1 = 11'd2047; m_t2 = 11'd2047;
                        setv = 8'h00; m_busy = RST;
                    end
                    5'h01: m_win = d[2:0];
                    5'h03: m_rx = 1'b0;
                    5'h04: m_rx = 1'b1;
                    5'h09: m_tx = 1'b1;
                    5'h0A: m_tx = 1'b0;
                    5'h0C: setv = setv | 8'h40;
                    5'h0D: clrv = d[7:0] & 8'hFE;
                    5'h0E: m_mask = d[7:0] & 8'hFE;
                    5'h11: m_t0 = d[10:0];
                    5'h12: m_t1 = d[10:0];
                    5'h13: m_t2 = d[10:0];
                    default: ;
                endcase
            end
            m_sticky = ((m_sticky & ~clrv) | setv) & 8'hFE;
        end
        q.push_back(snapshot(req));
    endtask

    function automatic logic [15:0] cw(input logic [4:0] op, input logic [10:0] arg);
        return {op, arg};
    endfunction

    // monitor: compares each expected item in the cycle it is due
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due <= cyc) begin
            compare(q.pop_front());
        end
    end

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R7 watchdog: actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R2 R3 R6 R8 R9: power-up values
        compare(snapshot("R3 power-up state"));

        // R2 window select, upper argument bits junk (R1)
        step(1'b1, cw(5'h01, 11'h7F5), 8'h00, "R2 window 5");
        step(1'b1, cw(5'h01, 11'h002), 8'h00, "R2 window 2");
        // R8 enables; R1 argument ignored on no-argument opcodes
        step(1'b1, cw(5'h04, 11'h7FF), 8'h00, "R1 R8 rx on, junk arg");
        step(1'b1, cw(5'h09, 11'h123), 8'h00, "R8 tx on");
        step(1'b1, cw(5'h03, 11'h000), 8'h00, "R8 rx off");
        step(1'b1, cw(5'h0A, 11'h555), 8'h00, "R8 tx off");
        // R10 events: bits 0 and 6 ignored
        step(1'b0, 16'h0, 8'hFF, "R10 all event pulses");
        step(1'b0, 16'h0, 8'h00, "R10 bits held, R3 layout");
        // R6 mask
        step(1'b1, cw(5'h0E, 11'h004), 8'h00, "R6 mask bit 2 raises latch");
        // R5 acknowledge
        step(1'b1, cw(5'h0D, 11'h004), 8'h00, "R5 ack bit 2 drops latch");
        step(1'b1, cw(5'h0D, 11'h023), 8'h00, "R5 ack bits 1 and 5");
        // R10 set beats ack
        step(1'b1, cw(5'h0D, 11'h010), 8'h10, "R10 set wins over ack");
        // R4 request interrupt, then mask it in
        step(1'b1, cw(5'h0C, 11'h3FF), 8'h00, "R4 interrupt requested");
        step(1'b1, cw(5'h0E, 11'h040), 8'h00, "R4 R6 irq from requested bit");
        step(1'b1, cw(5'h0D, 11'h0FF), 8'h00, "R5 ack all");
        // R9 thresholds
        step(1'b1, cw(5'h11, 11'd100), 8'h00, "R9 receive-early threshold");
        step(1'b1, cw(5'h12, 11'd2047), 8'h00, "R9 transmit-available disabled");
        step(1'b1, cw(5'h13, 11'd5), 8'h00, "R9 transmit-start threshold");
        step(1'b1, cw(5'h12, 11'd2046), 8'h00, "R9 2046 is enabled");
        // R11 unknown opcodes
        step(1'b1, cw(5'h02, 11'h7FF), 8'h00, "R11 opcode 0x02");
        step(1'b1, cw(5'h05, 11'h001), 8'h00, "R11 opcode 0x05");
        step(1'b1, cw(5'h0F, 11'h0FF), 8'h00, "R11 opcode 0x0F");
        step(1'b1, cw(5'h1F, 11'h7FF), 8'h00, "R11 opcode 0x1F");
        // set some state, then R7 global reset with an event in the same cycle
        step(1'b1, cw(5'h04, 11'h0), 8'h04, "R12 rx on and event");
        step(1'b1, cw(5'h00, 11'h7FF), 8'h80, "R7 global reset");
        for (int i = 0; i < RST; i++) begin
            step(1'b1, cw(5'h01, 11'h7), 8'hBE, "R7 busy ignores inputs");
        end
        step(1'b1, cw(5'h01, 11'h3), 8'h02, "R7 R12 accepted after busy");
        step(1'b1, cw(5'h09, 11'h0), 8'h00, "R8 tx on after reset");
        step(1'b0, 16'h0, 8'h00, "R12 idle");
        repeat (3) @(posedge clk);
        done = 1'b1;
        finish_run();
    end
endmodule